// File: doc/BRIEF.md
# DRAM Initialization Command Replayer

This block replays a short, software-written list of memory commands onto the DRAM command bus while the memory is being brought up, before normal traffic starts. Software fills up to sixteen slots. Each slot has two 32-bit words. The primary word carries the command itself, meaning the control-pin pattern and the bank or opcode fields. The secondary word carries an 11-bit address payload and a wait count. Software then writes the index of the last slot to run, which raises the busy flag. Hardware drives the slots one after another, each for a single cycle. After each command it holds a NOP gap whose length comes from that slot's wait count.

The wait count is stored with a bias. Software converts the wait it needs into clock periods, rounds up, and subtracts two, with zero as the floor. The block adds the two back as NOP cycles. A typical program is a NOP held with CKE high, then precharge-all, the four mode-register loads, a second precharge-all, two refreshes, and the final mode-register loads that leave OCD calibration.

In a precharge-all, address bit 10 is set. In a mode-register load, payload bits [9:8] select the register. When the busy flag drops, software writes the hand-over bit, and the controller then belongs to normal operation. Every pin is a plain control or status pin. The command bus has no back-pressure: it is written once per cycle and the memory cannot stall it.

Top module: `init_seq_top`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `init_done` and `cmd_strobe` are 0, and `cmd_word` and `cmd_addr` are zero. Every slot word also resets to zero.
- R2: A write with `slot_half`=0 stores the primary word of slot `slot_idx`. A write with `slot_half`=1 stores the secondary word. In the secondary word, bits [10:0] are the address payload, which appears on `cmd_addr`, and bits [31:11] are the stored wait D.
- R3: A `go_we` accepted at a clock edge sets `busy` at that edge. Slot 0 is driven at the next edge.
- R4: Each command is driven for exactly one cycle. During that cycle `cmd_strobe`=1 and `busy`=1.
- R5: After a command from a slot with stored wait D, there are exactly D+2 NOP cycles before the next command. During a NOP cycle `cmd_strobe`=0 and `cmd_word` and `cmd_addr` are zero.
- R6: `go_count`=N issues slots 0 to N in ascending order. N=0 issues slot 0 only, and N=15 issues all sixteen slots. `cmd_word` carries the primary word.
- R7: `busy` stays high through the NOP gap of the last slot. It falls at the edge where a following command would otherwise have started, and no command is issued then.
- R8: Slot writes are ignored while `busy` is high.
- R9: `go_we` is ignored while `busy` is high. The running count is left unchanged.
- R10: `done_we` sets `init_done`, which stays set until reset. `done_we` is ignored while `busy` is high.
- R11: Once `init_done` is set, `go_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_we | input | 1 | Slot word write strobe |
| slot_half | input | 1 | Selects the word written: 0 primary, 1 secondary |
| slot_idx | input | 4 | Slot written |
| slot_wdata | input | 32 | Word written |
| go_we | input | 1 | Starts the sequence |
| go_count | input | 4 | Index of the last slot to issue |
| done_we | input | 1 | Hand-over write: sets `init_done` |
| busy | output | 1 | Sequence valid flag; hardware clears it when the sequence finishes |
| init_done | output | 1 | Controller handed over to normal operation |
| cmd_strobe | output | 1 | A command is on the bus this cycle |
| cmd_word | output | 32 | Primary word of the slot being issued, zero on NOP |
| cmd_addr | output | 11 | Address payload of the slot being issued, zero on NOP |

## Verification
The bench goes after the gap arithmetic at the extremes. A stored wait of 0 must still give two NOP cycles. A design that drops the bias would put commands back to back, and one that counts the bias twice would stretch every gap. The bench also exercises count 0 and count 15: an off-by-one in the last-slot compare shows up either as a missing slot or as a seventeenth strobe that reads a stale word. Writes, restarts and the hand-over bit are all attempted while the sequence is running. A design that does not guard them would corrupt slot 0, cut the run short, or hand over too early. Finally, the bench times the fall of `busy`, which exposes a flag that clears at the last strobe instead of at the end of the last wait.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  localparam int ADDR_W = 11;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_e;
endpackage

// File: rtl/init_seq_slots.sv
module init_seq_slots #(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              half,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rd_pri,
  output logic [WORD_W-1:0] rd_sec
);
  logic [WORD_W-1:0] pri_arr [SLOTS];
  logic [WORD_W-1:0] sec_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : gen_slot
    logic [WORD_W-1:0] pri_q;
    logic [WORD_W-1:0] sec_q;
    logic              hit;

    assign hit = we && (widx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pri_q <= '0;
        sec_q <= '0;
      end else if (hit) begin
        if (half) sec_q <= wdata;
        else      pri_q <= wdata;
      end
    end

    assign pri_arr[i] = pri_q;
    assign sec_arr[i] = sec_q;
  end

  assign rd_pri = pri_arr[ridx];
  assign rd_sec = sec_arr[ridx];
endmodule

// File: rtl/init_seq_timer.sv
module init_seq_timer #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl
  import init_seq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int DLY_W = WORD_W - ADDR_W,
  localparam int CNT_W = DLY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_we,
  input  logic [IDX_W-1:0]  go_count,
  input  logic              done_we,
  input  logic [WORD_W-1:0] rd_pri,
  input  logic [WORD_W-1:0] rd_sec,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              busy,
  output logic              init_done,
  output logic              cmd_strobe,
  output logic [WORD_W-1:0] cmd_word,
  output logic [ADDR_W-1:0] cmd_addr
);
  sq_state_e        state_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] last_q;
  logic             go_ok;
  logic             issue;
  logic [DLY_W-1:0] slot_dly;

  assign busy     = (state_q != SQ_IDLE);
  assign go_ok    = go_we && !busy && !init_done;
  assign issue    = (state_q == SQ_RUN) && tmr_expired;
  assign rd_idx   = ptr_q;
  assign slot_dly = rd_sec[WORD_W-1:ADDR_W];

  // Timer: cleared on start, reloaded with the unbiased gap on each issue.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (go_ok) begin
      tmr_load = 1'b1;
    end else if (issue) begin
      tmr_load = 1'b1;
      tmr_val  = {1'b0, slot_dly} + CNT_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (go_ok) begin
            state_q <= SQ_RUN;
            ptr_q   <= '0;
            last_q  <= go_count;
          end
        end
        SQ_RUN: begin
          if (tmr_expired) begin
            if (ptr_q == last_q) state_q <= SQ_DRAIN;
            else                 ptr_q   <= ptr_q + IDX_W'(1);
          end
        end
        SQ_DRAIN: begin
          if (tmr_expired) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_strobe <= 1'b0;
      cmd_word   <= '0;
      cmd_addr   <= '0;
    end else if (issue) begin
      cmd_strobe <= 1'b1;
      cmd_word   <= rd_pri;
      cmd_addr   <= rd_sec[ADDR_W-1:0];
    end else begin
      cmd_strobe <= 1'b0;
      cmd_word   <= '0;
      cmd_addr   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  init_done <= 1'b0;
    else if (done_we && !busy)   init_done <= 1'b1;
  end

  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> busy); // R4
  AST_TWO_NOP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe ##1 !cmd_strobe); // R5
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_strobe |-> (cmd_word == '0 && cmd_addr == '0)); // R5
  AST_BUSY_FALL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!cmd_strobe && !$past(cmd_strobe))); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R10
  AST_DONE_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> !$past(busy)); // R10
  AST_NO_START_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !busy) |=> !busy); // R11
endmodule

// File: rtl/init_seq_top.sv
module init_seq_top
  import init_seq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int DLY_W = WORD_W - ADDR_W,
  localparam int CNT_W = DLY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_we,
  input  logic              slot_half,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic [WORD_W-1:0] slot_wdata,
  input  logic              go_we,
  input  logic [IDX_W-1:0]  go_count,
  input  logic              done_we,
  output logic              busy,
  output logic              init_done,
  output logic              cmd_strobe,
  output logic [WORD_W-1:0] cmd_word,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [WORD_W-1:0] rd_pri;
  logic [WORD_W-1:0] rd_sec;
  logic [IDX_W-1:0]  rd_idx;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic              store_we;

  assign store_we = slot_we && !busy;

  init_seq_slots #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (store_we),
    .half   (slot_half),
    .widx   (slot_idx),
    .wdata  (slot_wdata),
    .ridx   (rd_idx),
    .rd_pri (rd_pri),
    .rd_sec (rd_sec)
  );

  init_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  init_seq_ctrl #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_we       (go_we),
    .go_count    (go_count),
    .done_we     (done_we),
    .rd_pri      (rd_pri),
    .rd_sec      (rd_sec),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .rd_idx      (rd_idx),
    .busy        (busy),
    .init_done   (init_done),
    .cmd_strobe  (cmd_strobe),
    .cmd_word    (cmd_word),
    .cmd_addr    (cmd_addr)
  );

  AST_STRIKE_SEEN_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |=> !cmd_strobe); // R3
endmodule

// File: tb/init_seq_top_test.sv
module init_seq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_we = 1'b0;
  logic        slot_half = 1'b0;
  logic [3:0]  slot_idx = '0;
  logic [31:0] slot_wdata = '0;
  logic        go_we = 1'b0;
  logic [3:0]  go_count = '0;
  logic        done_we = 1'b0;
  logic        busy, init_done, cmd_strobe;
  logic [31:0] cmd_word;
  logic [10:0] cmd_addr;

  int checks = 0;
  int errors = 0;
  int strobes_seen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  init_seq_top uut (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .slot_half(slot_half),
    .slot_idx(slot_idx), .slot_wdata(slot_wdata), .go_we(go_we),
    .go_count(go_count), .done_we(done_we), .busy(busy),
    .init_done(init_done), .cmd_strobe(cmd_strobe), .cmd_word(cmd_word),
    .cmd_addr(cmd_addr)
  );

  // Behavioural reference: a queue of expected bus cycles.
  typedef struct { bit stb; logic [31:0] w; logic [10:0] a; } bus_t;
  bus_t        exp_q[$];
  logic [31:0] m_pri [16];
  logic [31:0] m_sec [16];
  bit          m_busy = 0, m_done = 0, e_stb = 0;
  logic [31:0] e_word = '0;
  logic [10:0] e_addr = '0;

  initial for (int i = 0; i < 16; i++) begin m_pri[i] = '0; m_sec[i] = '0; end

  always @(posedge clk) begin
    bit ob, go_ok;
    bus_t e;
    if (!rst_n) begin
      exp_q.delete();
      for (int i = 0; i < 16; i++) begin m_pri[i] = '0; m_sec[i] = '0; end
      m_busy = 0; m_done = 0; e_stb = 0; e_word = '0; e_addr = '0;
    end else begin
      ob = m_busy;
      go_ok = go_we && !ob && !m_done;
      if (slot_we && !ob) begin
        if (slot_half) m_sec[slot_idx] = slot_wdata;
        else           m_pri[slot_idx] = slot_wdata;
      end
      if (done_we && !ob) m_done = 1;
      if (go_ok) begin
        for (int k = 0; k <= int'(go_count); k++) begin
          e.stb = 1; e.w = m_pri[k]; e.a = m_sec[k][10:0];
          exp_q.push_back(e);
          for (int g = 0; g < int'(m_sec[k][31:11]) + 2; g++) begin
            e.stb = 0; e.w = '0; e.a = '0;
            exp_q.push_back(e);
          end
        end
        m_busy = 1; e_stb = 0; e_word = '0; e_addr = '0;
      end else if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        m_busy = 1; e_stb = e.stb; e_word = e.w; e_addr = e.a;
      end else begin
        m_busy = 0; e_stb = 0; e_word = '0; e_addr = '0;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmd_strobe) strobes_seen++;
    if (!finished) begin
      if (!rst_n) begin
        check(busy == 0 && init_done == 0 && cmd_strobe == 0, "R1 flags", {busy, init_done, cmd_strobe}, 0);
        check(cmd_word == 0 && cmd_addr == 0, "R1 bus", cmd_word | cmd_addr, 0);
      end else begin
        check(busy == m_busy, "R7 busy", busy, m_busy);
        check(cmd_strobe == e_stb, "R4 strobe", cmd_strobe, e_stb);
        check(cmd_word == e_word, "R6 word", cmd_word, e_word);
        check(cmd_addr == e_addr, "R2 addr", cmd_addr, e_addr);
        check(init_done == m_done, "R10 done", init_done, m_done);
      end
    end
  end

  task automatic load_slot(int i, logic [31:0] pri, logic [10:0] addr, int dly);
    slot_we = 1; slot_idx = 4'(i); slot_half = 0; slot_wdata = pri;
    @(negedge clk);
    slot_half = 1; slot_wdata = {21'(dly), addr};
    @(negedge clk);
    slot_we = 0;
  endtask

  task automatic start(int n, bit expect_run);
    go_we = 1; go_count = 4'(n);
    @(negedge clk);
    go_we = 0;
    if (expect_run) begin
      check(busy == 1 && cmd_strobe == 0, "R3 busy at start", {busy, cmd_strobe}, 2);
      @(negedge clk);
      check(cmd_strobe == 1, "R3 first strobe", cmd_strobe, 1);
    end
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (busy && lim < 5000) begin @(negedge clk); lim++; end
  endtask

  logic [31:0] first_pri;

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && cmd_strobe == 0, "R1 after reset", {busy, cmd_strobe}, 0);
    rst_n = 1;
    @(negedge clk);
    // Power-up style program in slots 0..11 (R2)
    first_pri = 32'hA500_0001;
    load_slot(0,  first_pri,    11'h000, 9);
    load_slot(1,  32'hA500_0002, 11'h400, 0);
    load_slot(2,  32'hA500_0003, 11'h200, 1);
    load_slot(3,  32'hA500_0004, 11'h300, 1);
    load_slot(4,  32'hA500_0005, 11'h100, 2);
    load_slot(5,  32'hA500_0006, 11'h00B, 3);
    load_slot(6,  32'hA500_0007, 11'h400, 0);
    load_slot(7,  32'hA500_0008, 11'h000, 40);
    load_slot(8,  32'hA500_0009, 11'h000, 5);
    load_slot(9,  32'hA500_000A, 11'h00A, 1);
    load_slot(10, 32'hA500_000B, 11'h103, 0);
    load_slot(11, 32'hA500_000C, 11'h100, 4);
    strobes_seen = 0;
    start(11, 1);
    // Disturbances during the run (R8, R9, R10)
    load_slot(0, 32'hDEAD_BEEF, 11'h7FF, 7);
    go_we = 1; go_count = 4'd2; done_we = 1;
    @(negedge clk);
    go_we = 0; done_we = 0;
    check(init_done == 0, "R10 ignored while busy", init_done, 0);
    wait_idle();
    check(strobes_seen == 12, "R9 run length kept", strobes_seen, 12);
    @(negedge clk);
    // Count 0: only slot 0, and it still holds the original word (R8, R6)
    strobes_seen = 0;
    start(0, 1);
    check(cmd_word == first_pri, "R8 slot untouched", cmd_word, first_pri);
    wait_idle();
    check(strobes_seen == 1, "R6 count zero", strobes_seen, 1);
    // Fill remaining slots, run all sixteen (R6)
    load_slot(12, 32'hB000_000D, 11'h001, 0);
    load_slot(13, 32'hB000_000E, 11'h002, 0);
    load_slot(14, 32'hB000_000F, 11'h003, 2);
    load_slot(15, 32'hB000_0010, 11'h004, 0);
    strobes_seen = 0;
    start(15, 1);
    wait_idle();
    check(strobes_seen == 16, "R6 count fifteen", strobes_seen, 16);
    // Hand-over, then restart attempt (R10, R11)
    done_we = 1;
    @(negedge clk);
    done_we = 0;
    check(init_done == 1, "R10 done set", init_done, 1);
    strobes_seen = 0;
    start(3, 0);
    check(busy == 0, "R11 go ignored", busy, 0);
    repeat (6) @(negedge clk);
    check(strobes_seen == 0 && init_done == 1, "R11 no commands", strobes_seen, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule